// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. A start request latches which analog channel to convert and how long to sample it. The block then drives the sample-and-hold through a timed sample phase and into a hold phase. In hold it runs one trial per result bit, most significant bit first. Each trial puts a code on the tap-selector bus and reads a single comparator bit back.

After the last trial, the decided code is copied into a result register and a one-cycle completion interrupt fires. The first result produced after reset carries a flag so that software can throw it away. The resistor string, the comparator and the sample-and-hold switch are analog and sit outside the block.

Top module: `sar_conv_seq`

## Requirements
- R1: With the block idle, `startReq` high at a rising edge starts a conversion: `busy` and `sampleEn` are high from the next cycle onward.
- R2: `chanLatched` takes `chanSel` only at an accepted start. A `startReq` seen while `busy` is high changes no output and does not alter the timing of the running conversion.
- R3: `sampleEn` stays high for exactly `sampleCycles` cycles, where 0 counts as 1. The value of `sampleCycles` is captured at the accepted start.
- R4: `holdEn` rises in the cycle after the last sample cycle and stays high until the completion cycle. `sampleEn` and `holdEn` are never high together.
- R5: In hold, trial k (k = 0 for bit 7, through k = 7 for bit 0) lasts `TRIAL_CYC` cycles. During trial k, `trialCode` equals the already decided upper bits, with bit 7-k set and all lower bits zero. The first trial therefore shows 0x80. Outside hold, `trialCode` is 0.
- R6: `cmpHigh` is sampled in the last cycle of each trial. A high value means the input is at or above the tap, and the trial bit is kept. A low value clears the trial bit.
- R7: In the cycle after the eighth decision, `resultData` shows the final code, `doneIrq` is high for exactly that one cycle, and `busy` is low. `resultData` holds its value until the next completion.
- R8: `firstFlag` goes to 1 with the first result after reset. It goes to 0 with every later result.
- R9: During and directly after reset, all outputs are 0.
- R10: A start request that is high in the completion cycle is accepted, so conversions can run back to back with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Conversion start request |
| chanSel | input | CH_W | Channel to convert |
| sampleCycles | input | SMP_W | Sample phase length in cycles (0 means 1) |
| cmpHigh | input | 1 | Comparator: analog input is at or above the tap |
| busy | output | 1 | Conversion in progress |
| chanLatched | output | CH_W | Channel captured at the accepted start |
| sampleEn | output | 1 | Sample-and-hold in sample (track) mode |
| holdEn | output | 1 | Sample-and-hold in hold mode |
| trialCode | output | DATA_W | Code sent to the tap selector |
| resultData | output | DATA_W | Last completed conversion result |
| doneIrq | output | 1 | One-cycle completion interrupt |
| firstFlag | output | 1 | Result is the first one after reset |

## Verification
Two functions can land in the same cycle: the completion of one conversion (result load and interrupt) and the acceptance of the next start. To provoke this, the bench holds `startReq` high across the end of a conversion. Under R10 the new start must be taken in the interrupt cycle, with `resultData` still showing the finished value while `sampleEn` rises one cycle later. A behavioural model that counts cycles since each start judges every output on every clock. The same model also judges start pulses that arrive mid-conversion with a different channel and sample length, and which must be ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } seqState_t;

  // Strobes from the sequencer control to the datapath
  typedef struct packed {
    logic captureCfg;  // accepted start: latch channel
    logic initSar;     // sample phase over: load first trial
    logic decideBit;   // last cycle of a trial: resolve the trial bit
    logic lastBit;     // the resolved bit is bit 0: latch result
  } strb_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SMP_W     = 8,
  parameter int TRIAL_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [SMP_W-1:0] sampleCycles,
  output logic             busy,
  output logic             sampleEn,
  output logic             holdEn,
  output strb_t            strb
);

  localparam int PH_W  = (TRIAL_CYC > 1) ? $clog2(TRIAL_CYC) : 1;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(TRIAL_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  seqState_t        state;
  logic [SMP_W-1:0] smpCnt;
  logic [PH_W-1:0]  phCnt;
  logic [BIT_W-1:0] bitCnt;

  logic accept, sampleDone, phaseEnd, onLastBit;

  assign accept     = (state == ST_IDLE) && startReq;
  assign sampleDone = (state == ST_SAMPLE) && (smpCnt <= SMP_W'(1));
  assign phaseEnd   = (state == ST_CONV) && (phCnt == PH_LAST);
  assign onLastBit  = (bitCnt == BIT_LAST);

  always_comb begin
    strb.captureCfg = accept;
    strb.initSar    = sampleDone;
    strb.decideBit  = phaseEnd;
    strb.lastBit    = phaseEnd && onLastBit;
  end

  assign busy     = (state != ST_IDLE);
  assign sampleEn = (state == ST_SAMPLE);
  assign holdEn   = (state == ST_CONV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      smpCnt <= '0;
      phCnt  <= '0;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_SAMPLE;
            smpCnt <= sampleCycles;
          end
        end
        ST_SAMPLE: begin
          if (sampleDone) begin
            state  <= ST_CONV;
            phCnt  <= '0;
            bitCnt <= '0;
          end else begin
            smpCnt <= smpCnt - SMP_W'(1);
          end
        end
        ST_CONV: begin
          if (phaseEnd) begin
            phCnt <= '0;
            if (onLastBit) state <= ST_IDLE;
            else           bitCnt <= bitCnt + BIT_W'(1);
          end else begin
            phCnt <= phCnt + PH_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: sample and hold are never requested together
  p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleEn && holdEn));

  // R4: hold is only entered straight out of the sample phase
  p_hold_after_sample_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEn) |-> $past(sampleEn));

  // R1: an idle start request begins sampling in the next cycle
  p_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> (busy && sampleEn));

endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              cmpHigh,
  output logic [CH_W-1:0]   chanLatched,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] resultData,
  output logic              doneIrq,
  output logic              firstFlag
);

  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sar;
  logic [DATA_W-1:0] trialMask;
  logic [DATA_W-1:0] sarResolved;
  logic              resultSeen;

  // Keep the trial bit when the input is at or above the tap
  assign sarResolved = cmpHigh ? sar : (sar & ~trialMask);
  assign trialCode   = sar;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanLatched <= '0;
      sar         <= '0;
      trialMask   <= '0;
      resultData  <= '0;
      doneIrq     <= 1'b0;
      firstFlag   <= 1'b0;
      resultSeen  <= 1'b0;
    end else begin
      doneIrq <= 1'b0;
      if (strb.captureCfg) chanLatched <= chanSel;
      if (strb.initSar) begin
        sar       <= MSB_ONE;
        trialMask <= MSB_ONE;
      end else if (strb.decideBit) begin
        if (strb.lastBit) begin
          resultData <= sarResolved;
          doneIrq    <= 1'b1;
          firstFlag  <= !resultSeen;
          resultSeen <= 1'b1;
          sar        <= '0;
          trialMask  <= '0;
        end else begin
          sar       <= sarResolved | (trialMask >> 1);
          trialMask <= trialMask >> 1;
        end
      end
    end
  end

  // R7: the completion interrupt lasts a single cycle
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R7: the result only changes together with the interrupt
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !doneIrq |-> $stable(resultData));

  // R2: the channel latch moves only after a captured start
  p_chan_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.captureCfg) |-> $stable(chanLatched));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CH_W      = 3,
  parameter int SMP_W     = 8,
  parameter int TRIAL_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [SMP_W-1:0]  sampleCycles,
  input  logic              cmpHigh,
  output logic              busy,
  output logic [CH_W-1:0]   chanLatched,
  output logic              sampleEn,
  output logic              holdEn,
  output logic [DATA_W-1:0] trialCode,
  output logic [DATA_W-1:0] resultData,
  output logic              doneIrq,
  output logic              firstFlag
);

  strb_t strb;

  sar_ctrl #(
    .DATA_W(DATA_W), .SMP_W(SMP_W), .TRIAL_CYC(TRIAL_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sampleCycles(sampleCycles),
    .busy(busy), .sampleEn(sampleEn), .holdEn(holdEn), .strb(strb)
  );

  sar_dpath #(
    .DATA_W(DATA_W), .CH_W(CH_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .chanSel(chanSel), .cmpHigh(cmpHigh),
    .chanLatched(chanLatched), .trialCode(trialCode), .resultData(resultData),
    .doneIrq(doneIrq), .firstFlag(firstFlag)
  );

  // R5: the first trial of every conversion presents only the MSB
  p_first_trial_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEn) |-> (trialCode == {1'b1, {(DATA_W-1){1'b0}}}));

  // R7: when the interrupt fires the sequencer is already idle
  p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !busy);

  // R5: no trial code is driven outside the hold phase
  p_code_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !holdEn |-> (trialCode == '0));

endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;

  localparam int TRIAL = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [2:0] chanSel = '0;
  logic [7:0] sampleCycles = '0;
  logic [7:0] vin = '0;
  logic       cmpHigh;
  logic       busy, sampleEn, holdEn, doneIrq, firstFlag;
  logic [2:0] chanLatched;
  logic [7:0] trialCode, resultData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  // Behavioural comparator: input at or above tap
  assign cmpHigh = (vin >= trialCode);

  sar_conv_seq #(.DATA_W(8), .CH_W(3), .SMP_W(8), .TRIAL_CYC(TRIAL)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .chanSel(chanSel),
    .sampleCycles(sampleCycles), .cmpHigh(cmpHigh), .busy(busy),
    .chanLatched(chanLatched), .sampleEn(sampleEn), .holdEn(holdEn),
    .trialCode(trialCode), .resultData(resultData), .doneIrq(doneIrq),
    .firstFlag(firstFlag)
  );

  // Reference model state
  int mBusy = 0, mTick = 0, mSmp = 1, mVin = 0, mChan = 0;
  int mResult = 0, mIrq = 0, mFirst = 0, mSeen = 0;

  always @(posedge clk) begin
    if (rstN) begin
      mIrq = 0;
      if (mBusy != 0) begin
        mTick++;
        if (mTick == mSmp + 8 * TRIAL) begin
          mBusy = 0;
          mIrq = 1;
          mResult = mVin;
          mFirst = (mSeen == 0) ? 1 : 0;
          mSeen = 1;
        end
      end else if (startReq) begin
        mBusy = 1;
        mTick = 0;
        mSmp = (sampleCycles == 0) ? 1 : int'(sampleCycles);
        mVin = int'(vin);
        mChan = int'(chanSel);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // Compare every output on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      int expSmp, expHold, expCode, k;
      expSmp  = (mBusy != 0 && mTick < mSmp) ? 1 : 0;
      expHold = (mBusy != 0 && mTick >= mSmp) ? 1 : 0;
      expCode = 0;
      if (expHold != 0) begin
        k = (mTick - mSmp) / TRIAL;
        expCode = (mVin & (~(255 >> k) & 255)) | (128 >> k);
      end
      chk("R1 busy", int'(busy), mBusy);
      chk("R2 chanLatched", int'(chanLatched), mChan);
      chk("R3 sampleEn", int'(sampleEn), expSmp);
      chk("R4 holdEn", int'(holdEn), expHold);
      chk("R5 trialCode", int'(trialCode), expCode);
      chk("R6 resultData", int'(resultData), mResult);
      chk("R7 doneIrq", int'(doneIrq), mIrq);
      chk("R8 firstFlag", int'(firstFlag), mFirst);
    end
  end

  task automatic waitDone();
    do @(negedge clk); while (!doneIrq);
  endtask

  task automatic convert(input int ch, input int sc, input int v, input bit noise);
    @(negedge clk);
    vin = 8'(v); chanSel = 3'(ch); sampleCycles = 8'(sc); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (noise) begin
      // R2: starts during sample and early trials must be ignored
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        startReq = (i % 2 == 0);
        chanSel = 3'(ch + 3);
        sampleCycles = 8'(sc + 7);
      end
      @(negedge clk);
      startReq = 1'b0;
    end
    waitDone();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs are zero while in reset
    chk("R9 busy", int'(busy), 0);
    chk("R9 sampleEn|holdEn", int'(sampleEn | holdEn), 0);
    chk("R9 trialCode", int'(trialCode), 0);
    chk("R9 resultData", int'(resultData), 0);
    chk("R9 doneIrq|firstFlag", int'(doneIrq | firstFlag), 0);
    chk("R9 chanLatched", int'(chanLatched), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    convert(1, 3, 8'hA5, 1'b0);  // R8: first result flagged
    convert(2, 0, 8'h00, 1'b1);  // R3: zero sample count means one cycle
    convert(7, 1, 8'hFF, 1'b0);
    convert(4, 5, 8'h80, 1'b1);
    convert(3, 2, 8'h7F, 1'b0);
    convert(6, 4, 8'h5A, 1'b1);
    convert(0, 9, 8'h01, 1'b0);

    // R10: start held high across completion is taken in the interrupt cycle
    @(negedge clk);
    vin = 8'hC3; chanSel = 3'd5; sampleCycles = 8'd2; startReq = 1'b1;
    waitDone();
    chk("R10 idle in irq cycle", int'(busy), 0);
    @(negedge clk);
    chk("R10 back-to-back accept", int'(sampleEn), 1);
    startReq = 1'b0;
    waitDone();
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule